// File: doc/BRIEF.md
# Pixel Threshold and RGB16 Packer

This block post-processes the 32-bit RGBA pixels that leave a colour converter, one pixel per clock. Two programmable 8-bit thresholds classify each pixel by its three colour channels. A dark pixel can be made fully transparent, with all 32 bits cleared. A slightly brighter pixel can be made semi-transparent, with its alpha byte forced to 0x40. Each pixel then passes through an optional sign flip, which turns its colour bytes into two's-complement form around mid-scale. An optional packer then reduces the pixel to a 16-bit 5:5:5:1 word.

Pixels arrive over a valid/ready stream and leave over another, in order. The output marks the last pixel of every 256-pixel (16x16) macroblock. A packed macroblock therefore fills 32 quadwords of 128 bits, and an unpacked one fills 64. The signed and packed mode bits travel with each pixel. A single command word loads both thresholds.

Top module: `pix_thresh_pack`

## Requirements
- R1: While reset is low and in the first cycle after it, out_valid is 0 and in_ready is 1. Both thresholds reset to 0.
- R2: A cycle with cfg_we high loads threshold T0 from cfg_word[7:0] and threshold T1 from cfg_word[23:16]. A pixel accepted in that same cycle still uses the old thresholds. Pixels accepted in later cycles use the new ones.
- R3: Pixel layout is R in bits [7:0], G in [15:8], B in [23:16] and alpha in [31:24]. When T0 is nonzero and R, G and B are each below T0, the thresholded pixel is all zero.
- R4: When the R3 rule does not fire and R, G and B are each below T1, alpha becomes 0x40 and the colours are unchanged. Otherwise the pixel is unchanged.
- R5: When T0 is zero, only the T1 test applies. When both thresholds are zero, pixels pass unchanged.
- R6: When in_signed is set, the three colour bytes of the thresholded pixel are XORed with 0x80 each, and alpha is kept.
- R7: When in_pack16 is set, out_is16 is 1 and out_data[31:16] is 0. out_data[4:0], [9:5] and [14:10] hold the top 5 bits of R, G and B, taken after the sign flip. out_data[15] is 1 exactly when the alpha after thresholding equals 0x40. When in_pack16 is clear, out_is16 is 0 and all 32 bits are output.
- R8: A pixel accepted on a clock edge is presented on the output from that edge on. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, the output holds stable. No pixel is lost, duplicated or reordered.
- R9: out_last is high on the 256th output pixel after reset and on every 256th pixel after it, and low on all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load thresholds from cfg_word |
| cfg_word | input | 32 | Threshold command word (T0 in [7:0], T1 in [23:16]) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_pix | input | 32 | Input RGBA pixel |
| in_signed | input | 1 | Apply sign flip to this pixel |
| in_pack16 | input | 1 | Pack this pixel to 5:5:5:1 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 32 | Processed pixel, packed form in [15:0] |
| out_is16 | output | 1 | out_data holds a packed pixel |
| out_last | output | 1 | Last pixel of a macroblock |

## Verification
Each processed pixel is due one clock after the edge that accepts it. The bench evaluates both handshakes at the falling edge. It queues the model result at the acceptance, and it pops and compares that result at the next output handshake. The model's thresholds update only after the current pixel's result is computed, which matches the one-edge delay of a threshold write. Stability under back-pressure is checked at each falling edge against the value seen one cycle earlier.

// File: rtl/pixpp_pkg.sv
package pixpp_pkg;
   localparam int CH_W = 8;
   localparam int PIX_W = 4 * CH_W;

   typedef struct packed {
      logic [CH_W-1:0] a;
      logic [CH_W-1:0] b;
      logic [CH_W-1:0] g;
      logic [CH_W-1:0] r;
   } rgba_t;
endpackage

// File: rtl/pixpp_thresh_regs.sv
module pixpp_thresh_regs #(
   parameter int CH_W   = 8,
   parameter int WORD_W = 32,
   parameter int T0_LSB = 0,
   parameter int T1_LSB = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] word,
   output logic [CH_W-1:0]   t0,
   output logic [CH_W-1:0]   t1
);
   if (T0_LSB + CH_W > WORD_W || T1_LSB + CH_W > WORD_W) begin : g_bad_field
      $error("threshold field outside command word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t0 <= '0;
         t1 <= '0;
      end else if (we) begin
         t0 <= word[T0_LSB +: CH_W];
         t1 <= word[T1_LSB +: CH_W];
      end
   end
endmodule

// File: rtl/pixpp_alpha_stage.sv
module pixpp_alpha_stage
   import pixpp_pkg::*;
#(
   parameter logic [CH_W-1:0] SEMI_A = 8'h40
) (
   input  rgba_t           pix_i,
   input  logic [CH_W-1:0] t0,
   input  logic [CH_W-1:0] t1,
   output rgba_t           pix_o
);
   localparam int NCH = 3;

   logic [CH_W-1:0] chan [NCH];
   logic [NCH-1:0]  under0;
   logic [NCH-1:0]  under1;
   logic            clear_hit;
   logic            semi_hit;

   assign chan[0] = pix_i.r;
   assign chan[1] = pix_i.g;
   assign chan[2] = pix_i.b;

   for (genvar c = 0; c < NCH; c++) begin : g_cmp
      assign under0[c] = chan[c] < t0;
      assign under1[c] = chan[c] < t1;
   end

   assign clear_hit = (t0 != '0) && (&under0);
   assign semi_hit  = &under1;

   always_comb begin
      pix_o = pix_i;
      if (clear_hit) begin
         pix_o = '0;
      end else if (semi_hit) begin
         pix_o.a = SEMI_A;
      end
   end
endmodule

// File: rtl/pixpp_format_stage.sv
module pixpp_format_stage
   import pixpp_pkg::*;
#(
   parameter int              PK_W   = 5,
   parameter logic [CH_W-1:0] SEMI_A = 8'h40
) (
   input  rgba_t            pix_i,
   input  logic             sgn,
   input  logic             pack,
   output logic [PIX_W-1:0] data_o,
   output logic             is16_o
);
   localparam int NCH   = 3;
   localparam int PACK_W = NCH * PK_W + 1;

   if (PK_W > CH_W || PK_W < 1) begin : g_bad_pack
      $error("packed channel width must be 1..CH_W");
   end

   rgba_t             flipped;
   logic [CH_W-1:0]   chan_in  [NCH];
   logic [CH_W-1:0]   chan_out [NCH];
   logic [PACK_W-1:0] packed_w;

   assign chan_in[0] = pix_i.r;
   assign chan_in[1] = pix_i.g;
   assign chan_in[2] = pix_i.b;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign chan_out[c] = {chan_in[c][CH_W-1] ^ sgn, chan_in[c][CH_W-2:0]};
      assign packed_w[c*PK_W +: PK_W] = chan_out[c][CH_W-1 -: PK_W];
   end

   assign packed_w[PACK_W-1] = (pix_i.a == SEMI_A);

   always_comb begin
      flipped   = pix_i;
      flipped.r = chan_out[0];
      flipped.g = chan_out[1];
      flipped.b = chan_out[2];
   end

   always_comb begin
      if (pack) begin
         data_o = {{(PIX_W-PACK_W){1'b0}}, packed_w};
      end else begin
         data_o = flipped;
      end
   end

   assign is16_o = pack;
endmodule

// File: rtl/pixpp_out_reg.sv
module pixpp_out_reg #(
   parameter int DATA_W  = 32,
   parameter int BLK_PIX = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   output logic              d_ready,
   input  logic [DATA_W-1:0] d_data,
   input  logic              d_is16,
   output logic              q_valid,
   input  logic              q_ready,
   output logic [DATA_W-1:0] q_data,
   output logic              q_is16,
   output logic              q_last
);
   localparam int CNT_W = (BLK_PIX > 1) ? $clog2(BLK_PIX) : 1;
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BLK_PIX - 1);

   if (BLK_PIX < 2) begin : g_bad_blk
      $error("macroblock must hold at least two pixels");
   end

   logic             take;
   logic [CNT_W-1:0] beat;

   assign d_ready = !q_valid || q_ready;
   assign take    = d_valid && d_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_data  <= '0;
         q_is16  <= 1'b0;
         q_last  <= 1'b0;
         beat    <= '0;
      end else if (take) begin
         q_valid <= 1'b1;
         q_data  <= d_data;
         q_is16  <= d_is16;
         q_last  <= (beat == CNT_END);
         beat    <= (beat == CNT_END) ? '0 : beat + 1'b1;
      end else if (q_ready) begin
         q_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pix_thresh_pack.sv
module pix_thresh_pack
   import pixpp_pkg::*;
#(
   parameter int              CMD_W   = 32,
   parameter int              PK_W    = 5,
   parameter int              BLK_PIX = 256,
   parameter logic [CH_W-1:0] SEMI_A  = 8'h40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CMD_W-1:0] cfg_word,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_pix,
   input  logic             in_signed,
   input  logic             in_pack16,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PIX_W-1:0] out_data,
   output logic             out_is16,
   output logic             out_last
);
   if (CMD_W < 24) begin : g_bad_cmd
      $error("command word too narrow for both thresholds");
   end

   logic [CH_W-1:0]  thr0;
   logic [CH_W-1:0]  thr1;
   rgba_t            thr_pix;
   logic [PIX_W-1:0] fmt_data;
   logic             fmt_is16;

   pixpp_thresh_regs #(
      .CH_W(CH_W), .WORD_W(CMD_W), .T0_LSB(0), .T1_LSB(16)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .word(cfg_word),
      .t0(thr0), .t1(thr1)
   );

   pixpp_alpha_stage #(.SEMI_A(SEMI_A)) u_alpha (
      .pix_i(rgba_t'(in_pix)), .t0(thr0), .t1(thr1), .pix_o(thr_pix)
   );

   pixpp_format_stage #(.PK_W(PK_W), .SEMI_A(SEMI_A)) u_fmt (
      .pix_i(thr_pix), .sgn(in_signed), .pack(in_pack16),
      .data_o(fmt_data), .is16_o(fmt_is16)
   );

   pixpp_out_reg #(.DATA_W(PIX_W), .BLK_PIX(BLK_PIX)) u_out (
      .clk(clk), .rst_n(rst_n),
      .d_valid(in_valid), .d_ready(in_ready),
      .d_data(fmt_data), .d_is16(fmt_is16),
      .q_valid(out_valid), .q_ready(out_ready),
      .q_data(out_data), .q_is16(out_is16), .q_last(out_last)
   );
endmodule

// File: rtl/pix_thresh_pack_checker.sv
module pix_thresh_pack_checker #(
   parameter int BLK_PIX = 256,
   parameter int PIX_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [PIX_W-1:0] out_data,
   input logic             out_is16,
   input logic             out_last
);
   localparam int CNT_W = $clog2(BLK_PIX) + 1;

   logic [CNT_W-1:0] sent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sent <= '0;
      end else if (out_valid && out_ready) begin
         sent <= (sent == CNT_W'(BLK_PIX - 1)) ? '0 : sent + 1'b1;
      end
   end

   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

   p_accept_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)
                                 && $stable(out_is16));

   p_pack_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_is16 |-> out_data[PIX_W-1:16] == '0);

   p_last_position_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_last |-> sent == CNT_W'(BLK_PIX - 1));
endmodule

bind pix_thresh_pack pix_thresh_pack_checker #(.BLK_PIX(BLK_PIX), .PIX_W(pixpp_pkg::PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_is16(out_is16), .out_last(out_last)
);

// File: tb/pix_thresh_pack_test.sv
module pix_thresh_pack_test;
   localparam int CLK_PERIOD = 10;
   localparam int BLK        = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_word = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_pix = '0;
   logic        in_signed = 1'b0;
   logic        in_pack16 = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;
   logic        out_is16;
   logic        out_last;

   pix_thresh_pack uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
      .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
      .in_signed(in_signed), .in_pack16(in_pack16),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_is16(out_is16), .out_last(out_last)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          checks = 0;
   int          fails = 0;
   int          out_cnt = 0;
   logic [7:0]  m_t0 = '0;
   logic [7:0]  m_t1 = '0;
   logic [31:0] exp_q [$];
   logic        e16_q [$];
   string       tag_q [$];
   logic        prev_hold = 1'b0;
   logic [31:0] prev_data = '0;
   logic        bp_en = 1'b0;
   logic [31:0] e_data;
   logic        e_16;
   string       e_tag;
   logic        e_last;

   function automatic logic [31:0] ref_pix(input logic [31:0] p, input logic [7:0] t0,
                                           input logic [7:0] t1, input logic sgn,
                                           input logic p16, output string tag);
      logic [31:0] q;
      q = p;
      if (t0 != 0 && p[7:0] < t0 && p[15:8] < t0 && p[23:16] < t0) begin
         q = '0;
         tag = "R3";
      end else if (p[7:0] < t1 && p[15:8] < t1 && p[23:16] < t1) begin
         q[31:24] = 8'h40;
         tag = (t0 == 0) ? "R5" : "R4";
      end else begin
         tag = (t0 == 0) ? "R5" : "R4";
      end
      if (sgn) begin
         q[23:0] = q[23:0] ^ 24'h808080;
         tag = "R6";
      end
      if (p16) begin
         q = {16'h0, q[31:24] == 8'h40, q[23:19], q[15:11], q[7:3]};
         tag = "R7";
      end
      return q;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hold) begin
            checks++;
            if (out_data !== prev_data || out_valid !== 1'b1)
               begin fails++; $display("FAIL R8 hold: data=%h valid=%b expected %h valid=1",
                                       out_data, out_valid, prev_data); end
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R8 extra output: data=%h expected none", out_data);
            end else begin
               e_data = exp_q.pop_front();
               e_16   = e16_q.pop_front();
               e_tag  = tag_q.pop_front();
               checks++;
               if (out_data !== e_data || out_is16 !== e_16) begin
                  fails++;
                  $display("FAIL %s pixel %0d: data=%h is16=%b expected %h is16=%b",
                           e_tag, out_cnt, out_data, out_is16, e_data, e_16);
               end
               e_last = (out_cnt % BLK) == BLK - 1;
               if (e_last || out_last) begin
                  checks++;
                  if (out_last !== e_last) begin
                     fails++;
                     $display("FAIL R9 pixel %0d: last=%b expected %b", out_cnt, out_last, e_last);
                  end
               end
               out_cnt++;
            end
         end
         prev_hold = out_valid && !out_ready;
         prev_data = out_data;
         if (in_valid && in_ready) begin
            exp_q.push_back(ref_pix(in_pix, m_t0, m_t1, in_signed, in_pack16, e_tag));
            e16_q.push_back(in_pack16);
            tag_q.push_back(cfg_we ? "R2" : e_tag);
         end
         if (cfg_we) begin
            m_t0 = cfg_word[7:0];
            m_t1 = cfg_word[23:16];
         end
      end
   end

   always @(posedge clk) begin
      #1 out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
   end

   task automatic send(input logic [31:0] p, input logic sgn, input logic p16);
      in_valid  = 1'b1;
      in_pix    = p;
      in_signed = sgn;
      in_pack16 = p16;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic set_thr(input logic [7:0] a, input logic [7:0] b);
      cfg_we   = 1'b1;
      cfg_word = {8'h5A, b, 8'hC3, a};
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   function automatic logic [7:0] rch();
      return (($urandom % 3) == 0) ? 8'($urandom % 48) : 8'($urandom);
   endfunction

   function automatic logic [31:0] rpix();
      logic [7:0] a;
      a = (($urandom % 5) == 0) ? 8'h40 : 8'($urandom);
      return {a, rch(), rch(), rch()};
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1 reset: valid=%b ready=%b expected 0 1", out_valid, in_ready);
      end
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R1 after reset: valid=%b ready=%b expected 0 1", out_valid, in_ready);
      end
      // R5: thresholds are zero after reset, pixels pass
      send(32'h40_10_20_30, 1'b0, 1'b0);
      send(32'h00_00_00_00, 1'b0, 1'b0);
      // R3/R4 corners around T0=0x20, T1=0x60
      set_thr(8'h20, 8'h60);
      send(32'h99_1F_1F_1F, 1'b0, 1'b0);
      send(32'h99_00_00_20, 1'b0, 1'b0);
      send(32'h99_00_60_00, 1'b0, 1'b0);
      send(32'h99_5F_5F_5F, 1'b1, 1'b0);
      send(32'h99_1F_1F_1F, 1'b1, 1'b0);
      send(32'h12_1F_50_FF, 1'b0, 1'b1);
      send(32'h12_10_50_58, 1'b1, 1'b1);
      // R5: T0 zero, T1 active; then T0 active, T1 zero
      set_thr(8'h00, 8'h10);
      send(32'h77_0F_0F_0F, 1'b0, 1'b0);
      send(32'h77_0F_10_0F, 1'b0, 1'b0);
      set_thr(8'h10, 8'h00);
      send(32'h77_0F_0F_0F, 1'b0, 1'b0);
      send(32'h40_0F_10_0F, 1'b0, 1'b1);
      // R2: write and pixel in the same cycle use old thresholds
      cfg_we   = 1'b1;
      cfg_word = 32'h0080_0000;
      send(32'h33_05_05_05, 1'b0, 1'b0);
      cfg_we   = 1'b0;
      send(32'h33_05_05_05, 1'b0, 1'b0);
      // random traffic with back-pressure
      bp_en = 1'b1;
      for (int i = 0; i < 1100; i++) begin
         if ((i % 97) == 0) set_thr(8'($urandom % 40), 8'($urandom % 100));
         send(rpix(), 1'($urandom), 1'($urandom));
      end
      bp_en = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R8 lost pixels: pending=%0d expected 0", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule